// File: doc/BRIEF.md
# Watchdog Counter with Stop-Mode Hold and Staged Wake-Up

This block is a watchdog counter that keeps its value while the system sits in a low-power stop state. A pulse on `stop_req` freezes the count, and a later pulse on `stop_release` starts a wake-up sequence. Counting resumes only when that sequence ends or when the CPU clock moves onto the external crystal, whichever happens first. The counter is never cleared by the pause. It advances only on `tick_en`, so it runs from the same operation clock after wake-up as before.

The wake-up sequence has two parts. First comes a fixed settling delay of 17 ticks. Then comes an oscillator stabilization wait whose length comes from the `stab_sel` code, sampled on the accepted release pulse. A 0-to-1 change of `cpu_on_xtal` during either part ends the wait at once. A restart command clears the count in every state. When the count reaches `OVF_VAL`, it wraps to zero and raises a one-cycle overflow pulse for the reset logic outside this block.

A four-state machine controls the behaviour. RUN is the counting state. STOPPED is the frozen state. HOLDOFF is the 17-tick settling delay. SETTLE is the stabilization wait. The transitions are:
- RUN→STOPPED on `stop_req`.
- STOPPED→HOLDOFF on `stop_release`.
- HOLDOFF→SETTLE when the 17th tick arrives.
- SETTLE→RUN when the stabilization period ends.
- HOLDOFF→RUN and SETTLE→RUN on a crystal switch edge.

Top module: `wdt_suspend`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `wd_count` is 0, `wd_active` is 1 (RUN) and `wd_overflow` is 0.
- R2: In RUN, each clock with `tick_en` high and no stop or restart raises `wd_count` by one in the following cycle. With `tick_en` low, the count holds.
- R3: A counted tick while `wd_count` equals `OVF_VAL` sets the count to 0 and drives `wd_overflow` high for exactly one cycle. At all other times `wd_overflow` is 0.
- R4: `wd_restart` high sets `wd_count` to 0 in the next cycle in every state. It takes priority over counting, and no overflow pulse results from it.
- R5: `stop_req` in RUN blocks the increment in that same cycle and moves the block to STOPPED, so `wd_active` is 0 from the next cycle.
- R6: `stop_release` in STOPPED starts the wait, and `wd_active` returns to 1 after 17 + 2^(STAB_BASE_LOG + STAB_STEP_LOG*s) ticks. Here s = min(`stab_sel`, 4), with `stab_sel` sampled on the release pulse. Cycles without `tick_en` do not advance the wait.
- R7: A 0-to-1 change of `cpu_on_xtal` (1 = external crystal, 0 = ring oscillator) seen in HOLDOFF or SETTLE puts the block in RUN in the next cycle.
- R8: Across STOPPED, HOLDOFF and SETTLE the count keeps its value, unless a restart clears it. After resume, counting continues from that value.
- R9: `stop_req` outside RUN and `stop_release` outside STOPPED have no effect on the state or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Watchdog operation-clock enable; advances the count and the wake-up wait |
| stop_req | input | 1 | Stop-mode entry pulse |
| stop_release | input | 1 | Stop-mode release pulse |
| stab_sel | input | 3 | Stabilization period code; 5 to 7 act as 4 |
| cpu_on_xtal | input | 1 | CPU clock source: 1 external crystal, 0 ring oscillator |
| wd_restart | input | 1 | Clear command for the count |
| wd_count | output | CNT_W | Current watchdog count |
| wd_overflow | output | 1 | One-cycle overflow / reset request |
| wd_active | output | 1 | High while the count is allowed to run (RUN) |

## Verification
Every result of this block is registered one edge after the input cycle that causes it. The count, the overflow pulse and the active flag therefore all fall due in the cycle after the stimulus. A resume after release falls due exactly 17 + period ticks later, and a resume after a crystal edge falls due one cycle after that edge. The driver applies inputs just after a falling edge and queues the expected outputs, tagged with the cycle number in which they fall due. The monitor compares each queued item at the falling edge of that cycle, so the long stabilization waits are checked on every cycle, including the last cycle before the resume.

// File: rtl/wdt_suspend_pkg.sv
package wdt_suspend_pkg;

    typedef enum logic [1:0] {
        WD_RUN     = 2'd0,
        WD_STOPPED = 2'd1,
        WD_HOLDOFF = 2'd2,
        WD_SETTLE  = 2'd3
    } wd_state_e;

    localparam int unsigned SEL_MAX = 4;

endpackage

// File: rtl/wdt_suspend_fsm.sv
module wdt_suspend_fsm
    import wdt_suspend_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_en,
    input  logic      stop_req,
    input  logic      stop_release,
    input  logic      cpu_on_xtal,
    input  logic      holdoff_done,
    input  logic      settle_done,
    output wd_state_e state,
    output logic      arm,
    output logic      holdoff_run,
    output logic      settle_run,
    output logic      count_en,
    output logic      active
);

    wd_state_e state_q, state_d;
    logic      xtal_q;
    logic      xtal_edge;

    assign xtal_edge = cpu_on_xtal & ~xtal_q;
    assign state     = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_RUN;
            xtal_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            xtal_q  <= cpu_on_xtal;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_RUN:     if (stop_req)          state_d = WD_STOPPED;
            WD_STOPPED: if (stop_release)      state_d = WD_HOLDOFF;
            WD_HOLDOFF: if (xtal_edge)         state_d = WD_RUN;
                        else if (holdoff_done) state_d = WD_SETTLE;
            WD_SETTLE:  if (xtal_edge || settle_done) state_d = WD_RUN;
            default:                           state_d = WD_RUN;
        endcase
    end

    // outputs
    always_comb begin
        arm         = 1'b0;
        holdoff_run = 1'b0;
        settle_run  = 1'b0;
        count_en    = 1'b0;
        active      = 1'b0;
        unique case (state_q)
            WD_RUN: begin
                active   = 1'b1;
                count_en = tick_en & ~stop_req;
            end
            WD_STOPPED: arm         = stop_release;
            WD_HOLDOFF: holdoff_run = 1'b1;
            WD_SETTLE:  settle_run  = 1'b1;
            default:    active      = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdt_suspend_timer.sv
module wdt_suspend_timer
    import wdt_suspend_pkg::*;
#(
    parameter int unsigned HOLDOFF_TICKS = 17,
    parameter int unsigned STAB_BASE_LOG = 11,
    parameter int unsigned STAB_STEP_LOG = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       arm,
    input  logic [2:0] stab_sel,
    input  logic       holdoff_run,
    input  logic       settle_run,
    output logic       holdoff_done,
    output logic       settle_done
);

    localparam int unsigned STAB_LOG_MAX = STAB_BASE_LOG + STAB_STEP_LOG * SEL_MAX;
    localparam int unsigned HOLD_W       = $clog2(HOLDOFF_TICKS) + 1;
    localparam int unsigned TMR_W        = (STAB_LOG_MAX > HOLD_W) ? STAB_LOG_MAX : HOLD_W;

    logic [TMR_W-1:0] tmr_q;
    logic [2:0]       sel_q;
    logic [TMR_W-1:0] settle_last;

    function automatic logic [TMR_W-1:0] period_last(input logic [2:0] code);
        int unsigned s;
        logic [TMR_W-1:0] one;
        s   = (int'(code) > int'(SEL_MAX)) ? SEL_MAX : int'(code);
        one = {{(TMR_W-1){1'b0}}, 1'b1};
        return (one << (STAB_BASE_LOG + STAB_STEP_LOG * s)) - one;
    endfunction

    assign settle_last  = period_last(sel_q);
    assign holdoff_done = holdoff_run & tick_en & (tmr_q == TMR_W'(HOLDOFF_TICKS - 1));
    assign settle_done  = settle_run  & tick_en & (tmr_q == settle_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
            sel_q <= '0;
        end else if (arm) begin
            tmr_q <= '0;
            sel_q <= stab_sel;
        end else if (holdoff_done) begin
            tmr_q <= '0;
        end else if ((holdoff_run || settle_run) && tick_en) begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_suspend_counter.sv
module wdt_suspend_counter #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned OVF_VAL = 65535
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVF_VAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            overflow <= 1'b0;
        end else if (clear) begin
            count    <= '0;
            overflow <= 1'b0;
        end else if (count_en && count == LAST) begin
            count    <= '0;
            overflow <= 1'b1;
        end else begin
            overflow <= 1'b0;
            if (count_en) count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_suspend.sv
module wdt_suspend
    import wdt_suspend_pkg::*;
#(
    parameter int unsigned CNT_W         = 16,
    parameter int unsigned OVF_VAL       = 65535,
    parameter int unsigned HOLDOFF_TICKS = 17,
    parameter int unsigned STAB_BASE_LOG = 11,
    parameter int unsigned STAB_STEP_LOG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             stop_req,
    input  logic             stop_release,
    input  logic [2:0]       stab_sel,
    input  logic             cpu_on_xtal,
    input  logic             wd_restart,
    output logic [CNT_W-1:0] wd_count,
    output logic             wd_overflow,
    output logic             wd_active
);

    wd_state_e state;
    logic      arm, holdoff_run, settle_run, holdoff_done, settle_done, count_en;

    wdt_suspend_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .stop_req     (stop_req),
        .stop_release (stop_release),
        .cpu_on_xtal  (cpu_on_xtal),
        .holdoff_done (holdoff_done),
        .settle_done  (settle_done),
        .state        (state),
        .arm          (arm),
        .holdoff_run  (holdoff_run),
        .settle_run   (settle_run),
        .count_en     (count_en),
        .active       (wd_active)
    );

    wdt_suspend_timer #(
        .HOLDOFF_TICKS (HOLDOFF_TICKS),
        .STAB_BASE_LOG (STAB_BASE_LOG),
        .STAB_STEP_LOG (STAB_STEP_LOG)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .arm          (arm),
        .stab_sel     (stab_sel),
        .holdoff_run  (holdoff_run),
        .settle_run   (settle_run),
        .holdoff_done (holdoff_done),
        .settle_done  (settle_done)
    );

    wdt_suspend_counter #(
        .CNT_W   (CNT_W),
        .OVF_VAL (OVF_VAL)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .clear    (wd_restart),
        .count    (wd_count),
        .overflow (wd_overflow)
    );

endmodule

// File: rtl/wdt_suspend_chk.sv
module wdt_suspend_chk
    import wdt_suspend_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned OVF_VAL = 65535
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             stop_req,
    input logic             stop_release,
    input logic             wd_restart,
    input logic [CNT_W-1:0] wd_count,
    input logic             wd_overflow,
    input logic             wd_active,
    input wd_state_e        state
);

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_active && tick_en && !stop_req && !wd_restart && wd_count != CNT_W'(OVF_VAL))
        |=> wd_count == $past(wd_count) + 1'b1);

    // R3
    ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_overflow |=> !wd_overflow);

    // R3
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_overflow |-> wd_count == '0);

    // R4
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_restart |=> (wd_count == '0 && !wd_overflow));

    // R5
    stop_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_active && stop_req && !wd_restart) |=> (!wd_active && $stable(wd_count)));

    // R6
    no_instant_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_STOPPED) |=> !wd_active);

    // R8
    paused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_active && !wd_restart) |=> $stable(wd_count));

    // R9
    stop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_HOLDOFF || state == WD_SETTLE) |=> state != WD_STOPPED);

endmodule

bind wdt_suspend wdt_suspend_chk #(
    .CNT_W   (CNT_W),
    .OVF_VAL (OVF_VAL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .stop_req     (stop_req),
    .stop_release (stop_release),
    .wd_restart   (wd_restart),
    .wd_count     (wd_count),
    .wd_overflow  (wd_overflow),
    .wd_active    (wd_active),
    .state        (state)
);

// File: tb/wdt_suspend_tb.sv
module wdt_suspend_tb;

    localparam int CNT_W = 8;
    localparam int OVF   = 20;
    localparam int HOLD  = 17;
    localparam int BASE  = 2;
    localparam int STEP  = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             tick_en, stop_req, stop_release, cpu_on_xtal, wd_restart;
    logic [2:0]       stab_sel;
    logic [CNT_W-1:0] wd_count;
    logic             wd_overflow, wd_active;

    always #5 clk = ~clk;

    wdt_suspend #(
        .CNT_W (CNT_W), .OVF_VAL (OVF), .HOLDOFF_TICKS (HOLD),
        .STAB_BASE_LOG (BASE), .STAB_STEP_LOG (STEP)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .stop_req (stop_req),
        .stop_release (stop_release), .stab_sel (stab_sel), .cpu_on_xtal (cpu_on_xtal),
        .wd_restart (wd_restart), .wd_count (wd_count), .wd_overflow (wd_overflow),
        .wd_active (wd_active)
    );

    typedef struct {
        int    due;
        int    cnt;
        bit    act;
        bit    ovf;
        string req;
    } item_t;

    item_t q[$];
    int    cyc    = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    // bench-side expectation state
    int m_cnt  = 0;
    int m_mode = 0;   // 0 counting, 1 frozen, 2 waking
    int m_wait = 0;
    bit m_prev_x = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (int'(wd_count) != it.cnt || wd_active !== it.act || wd_overflow !== it.ovf) begin
                errors++;
                $display("FAIL %s cycle %0d: count=%0d active=%0b ovf=%0b expected count=%0d active=%0b ovf=%0b",
                         it.req, cyc, wd_count, wd_active, wd_overflow, it.cnt, it.act, it.ovf);
            end
        end
    end

    function automatic int wake_len(input logic [2:0] sel);
        int s;
        s = (int'(sel) > 4) ? 4 : int'(sel);
        return HOLD + (1 << (BASE + STEP * s));
    endfunction

    // driver: applies one cycle of inputs and queues the outcome due next cycle
    task automatic step(input bit tk, input bit st, input bit rl, input bit cl,
                        input bit xt, input logic [2:0] sl, input string req);
        item_t it;
        bit    xedge;
        bit    ovf_n;
        @(negedge clk);
        tick_en = tk; stop_req = st; stop_release = rl; wd_restart = cl;
        cpu_on_xtal = xt; stab_sel = sl;
        xedge    = xt && !m_prev_x;
        m_prev_x = xt;
        ovf_n    = 1'b0;
        if (cl) m_cnt = 0;
        else if (m_mode == 0 && tk && !st) begin
            if (m_cnt == OVF) begin m_cnt = 0; ovf_n = 1'b1; end
            else m_cnt = m_cnt + 1;
        end
        case (m_mode)
            0: if (st) m_mode = 1;
            1: if (rl) begin m_mode = 2; m_wait = wake_len(sl); end
            default: begin
                if (xedge) m_mode = 0;
                else if (tk) begin
                    m_wait = m_wait - 1;
                    if (m_wait == 0) m_mode = 0;
                end
            end
        endcase
        it.due = cyc + 1; it.cnt = m_cnt; it.act = (m_mode == 0); it.ovf = ovf_n; it.req = req;
        q.push_back(it);
    endtask

    task automatic idle(input int n, input bit tk, input bit xt, input logic [2:0] sl, input string req);
        for (int i = 0; i < n; i++) step(tk, 0, 0, 0, xt, sl, req);
    endtask

    initial begin
        rst_n = 1'b0; tick_en = 0; stop_req = 0; stop_release = 0;
        cpu_on_xtal = 0; wd_restart = 0; stab_sel = 3'd0;
        repeat (3) @(negedge clk);
        checks++;   // R1 during reset
        if (wd_count !== '0 || wd_active !== 1'b1 || wd_overflow !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: count=%0d active=%0b ovf=%0b expected 0 1 0", wd_count, wd_active, wd_overflow);
        end
        rst_n = 1'b1;
        idle(1, 0, 0, 0, "R1");
        // R2 / R3: count up through two overflows
        idle(45, 1, 0, 0, "R2_R3");
        // R2: tick gating holds the count
        idle(6, 0, 0, 0, "R2");
        idle(3, 1, 0, 0, "R2");
        // R4: restart in counting state, then a restart exactly at the wrap value
        step(1, 0, 0, 1, 0, 0, "R4");
        idle(OVF, 1, 0, 0, "R2");
        step(1, 0, 0, 1, 0, 0, "R4");
        idle(5, 1, 0, 0, "R2");
        // R5: stop freezes, repeated stop ignored (R9)
        step(1, 1, 0, 0, 0, 0, "R5");
        idle(8, 1, 0, 0, "R8");
        step(1, 1, 0, 0, 0, 0, "R9");
        idle(3, 1, 0, 0, "R8");
        // R6: release with code 0, full wait, count preserved (R8)
        step(1, 0, 1, 0, 0, 3'd0, "R6");
        step(1, 1, 0, 0, 0, 3'd0, "R9");
        step(1, 0, 1, 0, 0, 3'd0, "R9");
        idle(wake_len(3'd0) + 6, 1, 0, 0, "R6_R8");
        // R9: release while counting ignored
        step(1, 0, 1, 0, 0, 0, "R9");
        idle(3, 1, 0, 0, "R9");
        // R7: crystal edge during the 17-tick hold-off
        step(1, 1, 0, 0, 0, 0, "R5");
        step(1, 0, 1, 0, 0, 3'd1, "R6");
        idle(5, 1, 0, 0, "R6");
        idle(6, 1, 1, 0, "R7");
        idle(2, 1, 0, 0, "R2");
        // R7: crystal edge during the stabilization wait
        step(1, 1, 0, 0, 0, 0, "R5");
        step(1, 0, 1, 0, 0, 3'd2, "R6");
        idle(HOLD + 13, 1, 0, 0, "R6");
        idle(4, 1, 1, 0, "R7");
        idle(2, 1, 0, 0, "R2");
        // R4 / R8: restart while frozen, then resume from zero
        step(1, 1, 0, 0, 0, 0, "R5");
        idle(3, 1, 0, 0, "R8");
        step(1, 0, 0, 1, 0, 0, "R4");
        step(1, 0, 1, 0, 0, 3'd1, "R6");
        idle(wake_len(3'd1) + 4, 1, 0, 0, "R6_R8");
        // R6: tick gaps stretch the wait
        step(1, 1, 0, 0, 0, 0, "R5");
        step(1, 0, 1, 0, 0, 3'd0, "R6");
        idle(10, 1, 0, 0, "R6");
        idle(7, 0, 0, 0, "R6");
        idle(wake_len(3'd0), 1, 0, 0, "R6");
        // R6: code 7 acts as code 4, sampled at release only
        step(1, 1, 0, 0, 0, 0, "R5");
        step(1, 0, 1, 0, 0, 3'd7, "R6");
        idle(wake_len(3'd4) + 4, 1, 0, 3'd0, "R6");
        idle(3, 1, 0, 0, "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule